// File: doc/BRIEF.md
# PCI Initiator Address Decoder and Address-Phase Sequencer

This block sits between a host processor and a PCI bus. It sorts each host access into one of three PCI cycle kinds. Host addresses inside a fixed high window become PCI memory cycles. Addresses inside a lower window become PCI I/O cycles. Accesses flagged by a separate configuration strobe become configuration cycles, of type 0 or type 1. Any access that does not qualify is refused with a one-clock reject pulse, and the bus is left untouched.

For an accepted access the block asks an external arbiter for the bus and waits for the grant. It then runs the address phase and a single data phase. A configuration cycle places its address on AD for one whole clock while FRAME# is still high. This gives resistively coupled IDSEL lines time to settle before the cycle begins. Memory and I/O cycles start FRAME# in the clock right after the grant is sampled.

Each cycle ends in one of two ways. If a target claims it with DEVSEL#, the block finishes normally and gives a one-clock done pulse. If no target claims it, the block ends it with a master abort and gives a one-clock abort pulse.

Top module: `pci_addr_seq`

## Requirements
- R1: While reset is active, and in the idle state, the outputs rest at these values: req_n, frame_n and irdy_n at 1; ad_oe at 0; ad_out at 0; cbe_n at 4'hF; done, mabort and reject at 0.
- R2: With cfg_req low, an address in the range 0xC000_0000 up to but excluding 0xFFE0_0000 starts a memory cycle. Its command on cbe_n is 4'b0110 for a read and 4'b0111 for a write, and AD carries the host address unchanged.
- R3: With cfg_req low, an address in the range 0x8100_0000 up to but excluding 0xBF80_0000 starts an I/O cycle. Its command on cbe_n is 4'b0010 for a read and 4'b0011 for a write, and AD carries the host address unchanged.
- R4: If cfg_req is low and the address lies in neither window, then reject is high for exactly the clock after start is sampled. req_n, frame_n and ad_oe do not change.
- R5: After start is accepted, req_n is low from the next clock on. It stays low through the clock in which gnt_n is sampled low, and goes high after that.
- R6: A configuration cycle (cfg_req high, command 4'b1010 read or 4'b1011 write) first has one pre-drive clock after the grant. In that clock ad_oe is 1, AD carries the address and frame_n is still 1. FRAME# is asserted in the clock after that. The address bits [1:0] are 2'b00 for type 0 and 2'b01 for type 1, and bits [31:2] come from the host address.
- R7: A memory or I/O cycle asserts frame_n in the first clock after the grant is sampled, with no pre-drive clock.
- R8: cpu_size gives the transfer size and must be 1 to 4 bytes. The value cpu_addr[1:0] + cpu_size must not exceed 4. If either rule fails, the access is rejected as in R4. In the data phase, cbe_n equals the inverse of a run of cpu_size ones that starts at lane cpu_addr[1:0].
- R9: If devsel_n is sampled low in any of the first five data-phase clocks, the cycle is claimed. The next clock has frame_n=1 and irdy_n=0. The clock after that returns to idle with done=1.
- R10: If devsel_n is not sampled low in those five data-phase clocks, the cycle is a master abort. One clock follows with frame_n=1 and irdy_n=0. Then irdy_n goes to 1 with mabort=1 for one clock.
- R11: While a cycle is in progress, start and the address inputs are ignored. The running cycle continues unchanged, and no reject pulse appears.
- R12: FRAME# is asserted for the address phase with ad_oe=1 and the command on cbe_n. It then stays asserted through the data phase, where ad_oe is 0 and irdy_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-clock pulse that offers a host access |
| cpu_addr | input | 32 | Host address |
| cpu_size | input | 3 | Transfer size in bytes |
| cpu_write | input | 1 | 1 for a write, 0 for a read |
| cfg_req | input | 1 | Treat the access as a configuration cycle |
| cfg_type1 | input | 1 | Configuration cycle type (1 = type 1) |
| gnt_n | input | 1 | Bus grant from the arbiter, active low |
| devsel_n | input | 1 | Target claim, active low |
| req_n | output | 1 | Bus request to the arbiter, active low |
| ad_oe | output | 1 | AD output enable |
| ad_out | output | 32 | Address value for AD |
| cbe_n | output | 4 | Command or byte enables, active low |
| frame_n | output | 1 | FRAME#, active low |
| irdy_n | output | 1 | IRDY#, active low |
| done | output | 1 | Claimed cycle finished (pulse) |
| mabort | output | 1 | Cycle ended by master abort (pulse) |
| reject | output | 1 | Access refused (pulse) |

## Verification
The assertions check every clock for the bus-ordering rules:
- the request and FRAME# never overlap;
- FRAME# falls only while AD is driven;
- a configuration cycle always shows a pre-drive clock, and other cycles never do;
- FRAME# always rises while IRDY# is low;
- a master abort follows the FRAME#-then-IRDY# release;
- at most one status pulse is high at a time.

Some behaviour depends on the stimulus and can only be shown by the bench's scenarios. This covers the exact window edges, the command and byte-lane values, the claim deadline at the fifth data clock, and the way inputs are ignored while busy. For these the bench drives chosen grant and DEVSEL# delays and compares every output on every clock.

// File: rtl/pci_addr_seq.sv
module pci_addr_seq #(
  parameter logic [31:0] MEM_LO      = 32'hC000_0000,
  parameter logic [31:0] MEM_HI      = 32'hFFE0_0000,
  parameter logic [31:0] IO_LO       = 32'h8100_0000,
  parameter logic [31:0] IO_HI       = 32'hBF80_0000,
  parameter int          DEVSEL_CLKS = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] cpu_addr,
  input  logic [2:0]  cpu_size,
  input  logic        cpu_write,
  input  logic        cfg_req,
  input  logic        cfg_type1,
  input  logic        gnt_n,
  input  logic        devsel_n,
  output logic        req_n,
  output logic        ad_oe,
  output logic [31:0] ad_out,
  output logic [3:0]  cbe_n,
  output logic        frame_n,
  output logic        irdy_n,
  output logic        done,
  output logic        mabort,
  output logic        reject
);

  localparam int CW = $clog2(DEVSEL_CLKS + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_REQ, S_PRE, S_ADDR, S_DATA, S_FIN, S_ABT, S_OK, S_MA
  } st_t;

  st_t         st;
  logic [31:0] ad_q;
  logic [3:0]  cmd_q;
  logic [3:0]  be_q;
  logic        cfg_q;
  logic        rej_q;
  logic [CW-1:0] cnt;

  logic        in_mem, in_io, size_ok, take;
  logic [3:0]  lane_mask, be_d, cmd_d;

  assign in_mem  = (cpu_addr >= MEM_LO) && (cpu_addr < MEM_HI);
  assign in_io   = (cpu_addr >= IO_LO) && (cpu_addr < IO_HI);
  assign size_ok = (cpu_size != 3'd0) && (cpu_size <= 3'd4) &&
                   (({2'b00, cpu_addr[1:0]} + {1'b0, cpu_size}) <= 4'd4);
  assign take    = size_ok && (cfg_req || in_mem || in_io);

  always_comb begin
    case (cpu_size)
      3'd1:    lane_mask = 4'b0001;
      3'd2:    lane_mask = 4'b0011;
      3'd3:    lane_mask = 4'b0111;
      default: lane_mask = 4'b1111;
    endcase
  end

  assign be_d  = lane_mask << cpu_addr[1:0];
  assign cmd_d = cfg_req ? {3'b101, cpu_write} :
                 in_mem  ? {3'b011, cpu_write} : {3'b001, cpu_write};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ad_q  <= '0;
      cmd_q <= '0;
      be_q  <= '0;
      cfg_q <= 1'b0;
      rej_q <= 1'b0;
      cnt   <= '0;
    end else begin
      rej_q <= (st == S_IDLE) && start && !take;
      case (st)
        S_IDLE: if (start && take) begin
          st    <= S_REQ;
          cfg_q <= cfg_req;
          cmd_q <= cmd_d;
          be_q  <= be_d;
          ad_q  <= cfg_req ? {cpu_addr[31:2], 1'b0, cfg_type1} : cpu_addr;
        end
        S_REQ:  if (!gnt_n) st <= cfg_q ? S_PRE : S_ADDR;
        S_PRE:  st <= S_ADDR;
        S_ADDR: begin
          st  <= S_DATA;
          cnt <= CW'(1);
        end
        S_DATA: begin
          if (!devsel_n)                  st <= S_FIN;
          else if (cnt == CW'(DEVSEL_CLKS)) st <= S_ABT;
          else                            cnt <= cnt + CW'(1);
        end
        S_FIN:  st <= S_OK;
        S_ABT:  st <= S_MA;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic addr_ph, irdy_ph;
  assign addr_ph = (st == S_PRE) || (st == S_ADDR);
  assign irdy_ph = (st == S_DATA) || (st == S_FIN) || (st == S_ABT);

  assign req_n   = (st != S_REQ);
  assign ad_oe   = addr_ph;
  assign ad_out  = addr_ph ? ad_q : 32'h0;
  assign cbe_n   = addr_ph ? cmd_q : (irdy_ph ? ~be_q : 4'hF);
  assign frame_n = !((st == S_ADDR) || (st == S_DATA));
  assign irdy_n  = !irdy_ph;
  assign done    = (st == S_OK);
  assign mabort  = (st == S_MA);
  assign reject  = rej_q;

endmodule

module pci_addr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_n,
  input logic frame_n,
  input logic irdy_n,
  input logic ad_oe,
  input logic done,
  input logic mabort,
  input logic reject,
  input logic cfg_q
);

  a_r9_status_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, mabort, reject}));

  a_r5_req_not_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !req_n |-> frame_n);

  a_r12_frame_with_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_n) |-> ad_oe);

  a_r6_predrive_clock: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(frame_n) && cfg_q) |-> ($past(ad_oe) && $past(frame_n) && $past(req_n)));

  a_r7_no_predrive: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(frame_n) && !cfg_q) |-> (!$past(req_n) && !$past(ad_oe)));

  a_r9_frame_before_irdy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_n) |-> !irdy_n);

  a_r10_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
    mabort |-> (irdy_n && $past(!irdy_n && frame_n)));

endmodule

bind pci_addr_seq pci_addr_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_n(req_n), .frame_n(frame_n), .irdy_n(irdy_n),
  .ad_oe(ad_oe), .done(done), .mabort(mabort), .reject(reject), .cfg_q(cfg_q)
);

// File: tb/pci_addr_seq_tb_top.sv
module pci_addr_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic [2:0]  cpu_size = '0;
  logic        cpu_write = 1'b0;
  logic        cfg_req = 1'b0;
  logic        cfg_type1 = 1'b0;
  logic        gnt_n = 1'b1;
  logic        devsel_n = 1'b1;
  logic        req_n, ad_oe, frame_n, irdy_n, done, mabort, reject;
  logic [31:0] ad_out;
  logic [3:0]  cbe_n;

  int nvec = 0;
  int nerr = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pci_addr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cpu_addr(cpu_addr),
    .cpu_size(cpu_size), .cpu_write(cpu_write), .cfg_req(cfg_req),
    .cfg_type1(cfg_type1), .gnt_n(gnt_n), .devsel_n(devsel_n),
    .req_n(req_n), .ad_oe(ad_oe), .ad_out(ad_out), .cbe_n(cbe_n),
    .frame_n(frame_n), .irdy_n(irdy_n), .done(done), .mabort(mabort),
    .reject(reject)
  );

  task automatic check(input string tag, input logic e_req, input logic e_oe,
                       input logic [31:0] e_ad, input logic [3:0] e_cbe,
                       input logic e_frame, input logic e_irdy, input logic e_done,
                       input logic e_ma, input logic e_rej);
    logic [72:0] act, exp;
    act = {req_n, ad_oe, ad_out, cbe_n, frame_n, irdy_n, done, mabort, reject,
           27'h0};
    exp = {e_req, e_oe, e_ad, e_cbe, e_frame, e_irdy, e_done, e_ma, e_rej, 27'h0};
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s t=%0t actual req=%b oe=%b ad=%h cbe=%h fr=%b ir=%b dn=%b ma=%b rj=%b expected req=%b oe=%b ad=%h cbe=%h fr=%b ir=%b dn=%b ma=%b rj=%b",
               tag, $time, req_n, ad_oe, ad_out, cbe_n, frame_n, irdy_n, done,
               mabort, reject, e_req, e_oe, e_ad, e_cbe, e_frame, e_irdy, e_done,
               e_ma, e_rej);
    end
  endtask

  task automatic check_idle(input string tag);
    check(tag, 1, 0, 32'h0, 4'hF, 1, 1, 0, 0, 0);
  endtask

  task automatic run(input string tag, input logic [31:0] addr, input logic [2:0] size,
                     input logic wr, input logic cfg, input logic t1,
                     input int g, input int d, input bit poke);
    bit ok, claimed;
    int a, last, lo, span;
    logic [31:0] ead;
    logic [3:0]  cmd, be;
    span = int'(addr[1:0]) + int'(size);
    ok = (size >= 1) && (size <= 4) && (span <= 4) &&
         (cfg || (addr >= 32'hC000_0000 && addr < 32'hFFE0_0000) ||
                 (addr >= 32'h8100_0000 && addr < 32'hBF80_0000));
    ead = cfg ? {addr[31:2], 1'b0, t1} : addr;
    cmd = cfg ? {3'b101, wr} : (addr >= 32'hC000_0000) ? {3'b011, wr} : {3'b001, wr};
    lo = int'(addr[1:0]);
    for (int i = 0; i < 4; i++) be[i] = (i >= lo) && (i < span);
    cpu_addr = addr; cpu_size = size; cpu_write = wr; cfg_req = cfg; cfg_type1 = t1;
    start = 1'b1;
    check_idle("R1 idle before start");
    @(negedge clk);
    start = 1'b0;
    if (!ok) begin
      check({tag, " reject"}, 1, 0, 32'h0, 4'hF, 1, 1, 0, 0, 1);
      @(negedge clk);
      check_idle({tag, " no bus activity after reject"});
      return;
    end
    a = cfg ? g + 2 : g + 1;
    claimed = (d >= 1) && (d <= 5);
    last = claimed ? a + d + 2 : a + 7;
    for (int c = 0; c <= last; c++) begin
      gnt_n = !(c == g);
      devsel_n = !(claimed && (c >= a + d) && (c <= a + d + 1));
      if (poke && c == 1) begin
        start = 1'b1; cpu_addr = 32'h0; cpu_size = 3'd0;
      end else begin
        start = 1'b0;
      end
      if (c <= g)
        check({tag, " R5 request"}, 0, 0, 32'h0, 4'hF, 1, 1, 0, 0, 0);
      else if (cfg && c == g + 1)
        check({tag, " R6 predrive"}, 1, 1, ead, cmd, 1, 1, 0, 0, 0);
      else if (c == a)
        check({tag, " R12 R7 address phase"}, 1, 1, ead, cmd, 0, 1, 0, 0, 0);
      else if (c > a && c <= a + (claimed ? d : 5))
        check({tag, " R12 R8 data phase"}, 1, 0, 32'h0, ~be, 0, 0, 0, 0, 0);
      else if (c == last - 1)
        check({tag, claimed ? " R9 release" : " R10 release"},
              1, 0, 32'h0, ~be, 1, 0, 0, 0, 0);
      else
        check({tag, claimed ? " R9 done" : " R10 abort"},
              1, 0, 32'h0, 4'hF, 1, 1, claimed, !claimed, 0);
      @(negedge clk);
    end
    start = 1'b0; gnt_n = 1'b1; devsel_n = 1'b1;
    check_idle({tag, " R11 back to idle"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog expired: actual running, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check_idle("R1 in reset");
    @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after reset");

    run("R2 mem read low edge", 32'hC000_0000, 3'd4, 0, 0, 0, 0, 1, 0);
    run("R2 mem write high edge", 32'hFFDF_FFFC, 3'd4, 1, 0, 0, 3, 3, 0);
    run("R4 just past mem window", 32'hFFE0_0000, 3'd4, 0, 0, 0, 0, 1, 0);
    run("R3 io write low edge", 32'h8100_0000, 3'd1, 1, 0, 0, 1, 2, 0);
    run("R3 R10 io read unclaimed", 32'hBF7F_FFFF, 3'd1, 0, 0, 0, 0, 0, 0);
    run("R4 just past io window", 32'hBF80_0000, 3'd1, 0, 0, 0, 0, 1, 0);
    run("R4 below io window", 32'h80FF_FFFF, 3'd1, 0, 0, 0, 0, 1, 0);
    run("R6 cfg type0 read", 32'h8000_0802, 3'd2, 0, 1, 0, 2, 1, 0);
    run("R6 cfg type1 write", 32'h8000_1000, 3'd3, 1, 1, 1, 0, 5, 0);
    run("R8 cfg crosses dword", 32'h8000_0803, 3'd2, 0, 1, 0, 0, 1, 0);
    run("R8 zero size", 32'hC000_0000, 3'd0, 0, 0, 0, 0, 1, 0);
    run("R8 size five", 32'hC000_0000, 3'd5, 0, 0, 0, 0, 1, 0);
    run("R8 mem three lanes", 32'hC000_0001, 3'd3, 1, 0, 0, 1, 4, 0);
    run("R10 mem unclaimed", 32'hD000_0000, 3'd2, 1, 0, 0, 2, 0, 0);
    run("R11 start while busy", 32'hC800_0004, 3'd4, 0, 0, 0, 2, 2, 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule